// File: doc/BRIEF.md
# UART Channel DMA-Ready and Interrupt Pin Driver

This block produces the per-channel status pins of a 16550-style serial channel. It does not hold any data. Its inputs are the receive and transmit occupancy reported by the FIFO logic, the receive trigger status, the holding-register flags used when the FIFOs are off, the FIFO-enable and DMA-mode control bits, the four interrupt enables, the four raw interrupt source flags and the modem-control output-2 bit. From these it drives two active-low DMA handshake pins (receive ready and transmit ready), the interrupt level with its output-enable, and the general-purpose output-2 pin.

Each handshake pin follows one of three rules. The rule is chosen by whether the FIFOs are enabled and which DMA mode is selected. With FIFOs on and mode 0 (single transfer), a pin shows plain empty/non-empty status. With FIFOs on and mode 1 (block transfer), a pin waits for the trigger or for the FIFO to become full. With FIFOs off, the pins use the single holding-register flags. A single control bit does two things: it moves the interrupt pin between active drive and high impedance, and it drives output-2 to the opposite level.

Every output is a register on the system clock. The reset input is active low. It clears the outputs at once and is released in step with the clock.

Top module: `uart_dma_irq_pins`

## Requirements
- R1: With fifo_en=1 and dma_mode=0, rxrdy_n is 0 exactly when rx_count is non-zero.
- R2: With fifo_en=1 and dma_mode=1, rxrdy_n is 0 exactly when rx_count is non-zero and rx_trig_hit is 1. Otherwise it is 1.
- R3: With fifo_en=0, rxrdy_n is the inverse of rhr_valid and txrdy_n is the inverse of thr_empty, for either value of dma_mode.
- R4: With fifo_en=1 and dma_mode=0, txrdy_n is 0 exactly when tx_count is zero, so one queued character raises it.
- R5: With fifo_en=1 and dma_mode=1, txrdy_n is 0 exactly when tx_count is below DEPTH, and 1 when the transmit FIFO is full.
- R6: With out2=1, irq_oe is 1 and op2 is 0. irq is 1 exactly when some bit i has both ier[i] and irq_src[i] set. The bits are: 0 receive data available, 1 transmit holding empty, 2 receiver line error, 3 modem status change.
- R7: With out2=0, irq_oe is 0, op2 is 1 and irq is held at 0, whatever ier and irq_src are.
- R8: While rst_n is 0, the outputs are rxrdy_n=1, txrdy_n=1, irq=0, irq_oe=0 and op2=1. They take these values without waiting for a clock edge and keep them for SYNC_STAGES edges after rst_n rises.
- R9: After reset has been released, each output reflects the inputs sampled at the previous rising clock edge. The delay is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | 0 single-transfer, 1 block-transfer signalling |
| rx_count | input | CNT_W | Characters held in the receive FIFO |
| rx_trig_hit | input | 1 | Receive FIFO has reached its programmed trigger level |
| rhr_valid | input | 1 | Receive holding register full (FIFOs off) |
| tx_count | input | CNT_W | Characters held in the transmit FIFO |
| thr_empty | input | 1 | Transmit holding register empty (FIFOs off) |
| ier | input | NSRC | Interrupt enables, bit order as in R6 |
| irq_src | input | NSRC | Raw interrupt conditions, same bit order |
| out2 | input | 1 | Modem-control output-2 bit |
| rxrdy_n | output | 1 | Receive ready, active low |
| txrdy_n | output | 1 | Transmit ready, active low |
| irq | output | 1 | Interrupt level, active high while driven |
| irq_oe | output | 1 | Output-enable for the interrupt pad |
| op2 | output | 1 | User output 2 |

## Verification
The assertions assume that rx_count and tx_count never go above DEPTH. They also assume the control inputs are steady for the whole cycle around each clock edge. The timing checks use the one-cycle-earlier inputs only after the synchronised reset has been high for one edge. The bench changes every input at the falling clock edge. It sweeps occupancy from 0 up to DEPTH and never beyond. It also tries combinations that cannot occur in a real channel, such as a set trigger flag with an empty FIFO, so that the gating in R2 is tested.

// File: rtl/uart_pin_pkg.sv
package uart_pin_pkg;

  typedef enum logic [1:0] {
    PATH_HOLD   = 2'd0,
    PATH_SINGLE = 2'd1,
    PATH_BLOCK  = 2'd2
  } ready_path_e;

  localparam int SRC_RXDATA = 0;
  localparam int SRC_THRE   = 1;
  localparam int SRC_LINE   = 2;
  localparam int SRC_MODEM  = 3;

  function automatic ready_path_e pick_path(input logic fifo_on, input logic blk);
    ready_path_e p;
    if (!fifo_on)  p = PATH_HOLD;
    else if (blk)  p = PATH_BLOCK;
    else           p = PATH_SINGLE;
    return p;
  endfunction

endpackage

// File: rtl/upin_rst_sync.sv
module upin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/upin_rx_ready.sv
module upin_rx_ready
  import uart_pin_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             upd_en,
  input  ready_path_e      path,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_trig_hit,
  input  logic             rhr_valid,
  output logic             rxrdy_n
);
  logic has_data;
  logic rdy_n_d;

  assign has_data = (rx_count != '0);

  always_comb begin
    case (path)
      PATH_HOLD:   rdy_n_d = ~rhr_valid;
      PATH_SINGLE: rdy_n_d = ~has_data;
      PATH_BLOCK:  rdy_n_d = ~(has_data & rx_trig_hit);
      default:     rdy_n_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      rxrdy_n <= 1'b1;
    else if (upd_en) rxrdy_n <= rdy_n_d;
  end
endmodule

// File: rtl/upin_tx_ready.sv
module upin_tx_ready
  import uart_pin_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             upd_en,
  input  ready_path_e      path,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             thr_empty,
  output logic             txrdy_n
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic is_empty;
  logic has_room;
  logic rdy_n_d;

  assign is_empty = (tx_count == '0);
  assign has_room = (tx_count < FULL);

  always_comb begin
    case (path)
      PATH_HOLD:   rdy_n_d = ~thr_empty;
      PATH_SINGLE: rdy_n_d = ~is_empty;
      PATH_BLOCK:  rdy_n_d = ~has_room;
      default:     rdy_n_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      txrdy_n <= 1'b1;
    else if (upd_en) txrdy_n <= rdy_n_d;
  end
endmodule

// File: rtl/upin_irq_ctl.sv
module upin_irq_ctl #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic            upd_en,
  input  logic [NSRC-1:0] ier,
  input  logic [NSRC-1:0] irq_src,
  input  logic            out2,
  output logic            irq,
  output logic            irq_oe,
  output logic            op2
);
  logic [NSRC-1:0] hit;
  logic            irq_d;
  logic            oe_d;
  logic            op2_d;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = ier[i] & irq_src[i];
    end
  endgenerate

  always_comb begin
    oe_d  = out2;
    op2_d = ~out2;
    irq_d = out2 & (|hit);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq    <= 1'b0;
      irq_oe <= 1'b0;
      op2    <= 1'b1;
    end else if (upd_en) begin
      irq    <= irq_d;
      irq_oe <= oe_d;
      op2    <= op2_d;
    end
  end
endmodule

// File: rtl/uart_dma_irq_pins.sv
module uart_dma_irq_pins
  import uart_pin_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int NSRC        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_trig_hit,
  input  logic             rhr_valid,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             thr_empty,
  input  logic [NSRC-1:0]  ier,
  input  logic [NSRC-1:0]  irq_src,
  input  logic             out2,
  output logic             rxrdy_n,
  output logic             txrdy_n,
  output logic             irq,
  output logic             irq_oe,
  output logic             op2
);
  logic        rst_q;
  logic        upd_en;
  ready_path_e path;

  assign upd_en = 1'b1;
  assign path   = pick_path(fifo_en, dma_mode);

  upin_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  upin_rx_ready #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_q(rst_q), .upd_en(upd_en), .path(path),
    .rx_count(rx_count), .rx_trig_hit(rx_trig_hit),
    .rhr_valid(rhr_valid), .rxrdy_n(rxrdy_n)
  );

  upin_tx_ready #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_q(rst_q), .upd_en(upd_en), .path(path),
    .tx_count(tx_count), .thr_empty(thr_empty), .txrdy_n(txrdy_n)
  );

  upin_irq_ctl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_q(rst_q), .upd_en(upd_en), .ier(ier),
    .irq_src(irq_src), .out2(out2), .irq(irq), .irq_oe(irq_oe), .op2(op2)
  );
endmodule

// File: rtl/uart_dma_irq_pins_chk.sv
module uart_dma_irq_pins_chk #(
  parameter int DEPTH = 16,
  parameter int NSRC  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_q,
  input logic             fifo_en,
  input logic             dma_mode,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_trig_hit,
  input logic [CNT_W-1:0] tx_count,
  input logic [NSRC-1:0]  ier,
  input logic [NSRC-1:0]  irq_src,
  input logic             rxrdy_n,
  input logic             txrdy_n,
  input logic             irq,
  input logic             irq_oe,
  input logic             op2
);
  logic seen;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_op2_opposite_R7: assert property (@(posedge clk) disable iff (!rst_q)
    op2 == !irq_oe);

  assert_hiz_quiet_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !irq_oe |-> !irq);

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (seen && irq_oe) |-> (irq == ($past(ier & irq_src) != '0)));

  assert_rx_single_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (seen && $past(fifo_en) && !$past(dma_mode)) |-> (rxrdy_n == ($past(rx_count) == '0)));

  assert_rx_block_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (seen && $past(fifo_en) && $past(dma_mode) && !$past(rx_trig_hit)) |-> rxrdy_n);

  assert_tx_block_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (seen && $past(fifo_en) && $past(dma_mode)) |-> (txrdy_n == ($past(tx_count) >= CNT_W'(DEPTH))));

  assert_tx_single_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (seen && $past(fifo_en) && !$past(dma_mode)) |-> (txrdy_n == ($past(tx_count) != '0)));
endmodule

bind uart_dma_irq_pins uart_dma_irq_pins_chk #(.DEPTH(DEPTH), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_q(rst_q), .fifo_en(fifo_en), .dma_mode(dma_mode),
  .rx_count(rx_count), .rx_trig_hit(rx_trig_hit), .tx_count(tx_count),
  .ier(ier), .irq_src(irq_src), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
  .irq(irq), .irq_oe(irq_oe), .op2(op2)
);

// File: tb/sim_uart_dma_irq_pins.sv
`timescale 1ns/1ps
module sim_uart_dma_irq_pins;
  localparam int DEPTH = 16;
  localparam int NSRC  = 4;
  localparam int SYNC  = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic fifo_en, dma_mode, rx_trig_hit, rhr_valid, thr_empty, out2;
  logic [CW-1:0] rx_count, tx_count;
  logic [NSRC-1:0] ier, irq_src;
  logic rxrdy_n, txrdy_n, irq, irq_oe, op2;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_dma_irq_pins #(.DEPTH(DEPTH), .NSRC(NSRC), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .rx_count(rx_count), .rx_trig_hit(rx_trig_hit), .rhr_valid(rhr_valid),
    .tx_count(tx_count), .thr_empty(thr_empty), .ier(ier), .irq_src(irq_src),
    .out2(out2), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .irq(irq),
    .irq_oe(irq_oe), .op2(op2)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_reset(input string tag);
    chk({tag, " rxrdy_n"}, rxrdy_n, 1'b1);
    chk({tag, " txrdy_n"}, txrdy_n, 1'b1);
    chk({tag, " irq"},     irq,     1'b0);
    chk({tag, " irq_oe"},  irq_oe,  1'b0);
    chk({tag, " op2"},     op2,     1'b1);
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset;
    rst_n = 1'b1;
    for (int k = 0; k < SYNC; k++) begin
      step();
      chk_reset("R8 hold after release");
    end
    step();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fifo_en = 1'b1; dma_mode = 1'b0; rx_trig_hit = 1'b1; rhr_valid = 1'b1;
    thr_empty = 1'b1; out2 = 1'b1; rx_count = 5; tx_count = 0;
    ier = '1; irq_src = '1;
    repeat (3) step();
    chk_reset("R8 during reset");
    release_reset();

    // R1 R2 R3: receive-ready sweep
    for (int f = 0; f < 2; f++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c <= DEPTH; c++)
          for (int t = 0; t < 2; t++)
            for (int h = 0; h < 2; h++) begin
              logic e;
              fifo_en = f[0]; dma_mode = m[0]; rx_count = c[CW-1:0];
              rx_trig_hit = t[0]; rhr_valid = h[0];
              step();
              if (f == 0) begin
                e = ~h[0];
                chk("R3 rxrdy_n hold", rxrdy_n, e);
              end else if (m == 0) begin
                e = (c == 0);
                chk("R1 rxrdy_n single", rxrdy_n, e);
              end else begin
                e = !((c != 0) && (t == 1));
                chk("R2 rxrdy_n block", rxrdy_n, e);
              end
            end

    // R3 R4 R5: transmit-ready sweep
    for (int f = 0; f < 2; f++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c <= DEPTH; c++)
          for (int h = 0; h < 2; h++) begin
            logic e;
            fifo_en = f[0]; dma_mode = m[0]; tx_count = c[CW-1:0];
            thr_empty = h[0];
            step();
            if (f == 0) begin
              e = ~h[0];
              chk("R3 txrdy_n hold", txrdy_n, e);
            end else if (m == 0) begin
              e = (c != 0);
              chk("R4 txrdy_n single", txrdy_n, e);
            end else begin
              e = (c >= DEPTH);
              chk("R5 txrdy_n block", txrdy_n, e);
            end
          end

    // R6 R7: interrupt and output-2 sweep
    for (int o = 0; o < 2; o++)
      for (int en = 0; en < 16; en++)
        for (int s = 0; s < 16; s++) begin
          out2 = o[0]; ier = en[3:0]; irq_src = s[3:0];
          step();
          if (o == 1) begin
            chk("R6 irq level", irq, ((en & s) != 0));
            chk("R6 irq_oe", irq_oe, 1'b1);
            chk("R6 op2", op2, 1'b0);
          end else begin
            chk("R7 irq quiet", irq, 1'b0);
            chk("R7 irq_oe", irq_oe, 1'b0);
            chk("R7 op2", op2, 1'b1);
          end
        end

    // R9: an input change shows exactly one edge later
    fifo_en = 1'b1; dma_mode = 1'b0; rx_count = 0; out2 = 1'b0;
    step();
    rx_count = 3; out2 = 1'b1;
    #2;
    chk("R9 rxrdy_n before edge", rxrdy_n, 1'b1);
    chk("R9 op2 before edge", op2, 1'b1);
    step();
    chk("R9 rxrdy_n after edge", rxrdy_n, 1'b0);
    chk("R9 op2 after edge", op2, 1'b0);

    // R8: asynchronous assertion of reset mid-run
    tx_count = 2;
    step();
    #3 rst_n = 1'b0;
    #1;
    chk_reset("R8 async assert");
    step();
    chk_reset("R8 held");
    release_reset();
    chk("R8 resume rxrdy_n", rxrdy_n, 1'b0);
    chk("R8 resume txrdy_n", txrdy_n, 1'b1);
    chk("R8 resume op2", op2, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule